// File: doc/BRIEF.md
# Control Endpoint Receive Re-arm Guard

This block sits between the event stream of a USB device controller's control endpoint and the logic that builds a receive descriptor. A NAK on the control OUT endpoint starts one descriptor-preparation sequence. The guard then blocks every later NAK until that sequence is retired. Without the guard, a second NAK that arrives mid-preparation could start a second write over a descriptor that is only half written.

All inputs are single-cycle event pulses. There are four of them: an OUT-NAK, a SETUP, an OUT-received and a preparation-done. The guard answers with three outputs:
- a registered start pulse;
- a busy flag, which stays high while the preparation is in progress and while the buffer is queued;
- a saturating count of the NAK events it has swallowed.

A SETUP or an OUT-received retires the buffer and lets the next NAK start a fresh preparation.

Top module: `ep0_rearm_guard`

## Requirements
- R1: An OUT-NAK sampled while busy is 0 drives startPrep high for exactly one cycle, in the cycle after the sampling edge, and busy reads 1 from that same cycle.
- R2: An OUT-NAK sampled while busy is 1 (with no SETUP or OUT-received in that cycle) produces no startPrep pulse and leaves busy at 1.
- R3: A SETUP event drives busy to 0 in the cycle after it is sampled.
- R4: An OUT-received event drives busy to 0 in the cycle after it is sampled.
- R5: A preparation-done event changes neither busy, startPrep nor dropCount.
- R6: When a SETUP or OUT-received coincides with an OUT-NAK, the clear wins: busy reads 0 and startPrep reads 0 in the next cycle, and one cycle later startPrep pulses and busy reads 1.
- R7: Each suppressed OUT-NAK (the R2 case) adds exactly one to dropCount.
- R8: dropCount saturates at 2^CNT_W-1 (15 with the default CNT_W=4) and holds there on further suppressed NAKs.
- R9: After synchronous reset (rst high at a clock edge), busy, startPrep and dropCount are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nakEvt | input | 1 | OUT-NAK event pulse |
| setupEvt | input | 1 | SETUP event pulse |
| outRcvEvt | input | 1 | OUT data received event pulse |
| prepDone | input | 1 | Descriptor preparation finished pulse |
| startPrep | output | 1 | One-cycle request to prepare and queue the receive buffer |
| busy | output | 1 | Preparation in progress or buffer queued |
| dropCount | output | CNT_W | Saturating count of suppressed NAK events |

## Verification
The colliding pair is the arrival of a NAK and a clear, where the clear is a SETUP or an OUT-received. Both can be sampled at the same edge. The bench first makes the guard busy. It then drives each clear together with a NAK in a single cycle. It then judges the result cycle by cycle:
- the next cycle must show busy low and no start pulse, which shows the clear took priority;
- the cycle after must show exactly one start pulse with busy raised, which shows the NAK was deferred and not lost;
- the drop counter must not move across the whole exchange.

// File: rtl/ep0_guard_pkg.sv
package ep0_guard_pkg;

  // Guard phases: idle, descriptor being prepared, buffer queued awaiting data
  typedef enum logic [1:0] {
    G_IDLE   = 2'd0,
    G_PREP   = 2'd1,
    G_QUEUED = 2'd2
  } guard_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startReq;
    logic dropInc;
  } guard_strb_t;

endpackage

// File: rtl/ep0_guard_ctrl.sv
module ep0_guard_ctrl
  import ep0_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        nakEvt,
  input  logic        setupEvt,
  input  logic        outRcvEvt,
  input  logic        prepDone,
  output logic        busy,
  output guard_strb_t strb
);

  guard_state_t stateQ, stateD;
  logic deferQ, deferD;
  logic clearEvt, effNak;

  always_comb begin
    clearEvt = setupEvt | outRcvEvt;
    effNak   = nakEvt | deferQ;
    stateD   = stateQ;
    deferD   = 1'b0;
    strb     = '0;
    if (clearEvt) begin
      // a clear wins; a coincident NAK is replayed next cycle
      stateD = G_IDLE;
      deferD = effNak;
    end else begin
      case (stateQ)
        G_IDLE: begin
          if (effNak) begin
            stateD        = G_PREP;
            strb.startReq = 1'b1;
          end
        end
        G_PREP: begin
          if (effNak) strb.dropInc = 1'b1;
          if (prepDone) stateD = G_QUEUED;
        end
        G_QUEUED: begin
          if (effNak) strb.dropInc = 1'b1;
        end
        default: stateD = G_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= G_IDLE;
      deferQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      deferQ <= deferD;
    end
  end

  assign busy = (stateQ != G_IDLE);

endmodule

// File: rtl/ep0_guard_dp.sv
module ep0_guard_dp
  import ep0_guard_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  guard_strb_t      strb,
  output logic             startPrep,
  output logic [CNT_W-1:0] dropCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             startQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      startQ <= strb.startReq;
      if (strb.dropInc && (cntQ != CNT_MAX)) cntQ <= cntQ + 1'b1;
    end
  end

  assign startPrep = startQ;
  assign dropCount = cntQ;

endmodule

// File: rtl/ep0_rearm_guard.sv
module ep0_rearm_guard
  import ep0_guard_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nakEvt,
  input  logic             setupEvt,
  input  logic             outRcvEvt,
  input  logic             prepDone,
  output logic             startPrep,
  output logic             busy,
  output logic [CNT_W-1:0] dropCount
);

  guard_strb_t strb;

  ep0_guard_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .nakEvt    (nakEvt),
    .setupEvt  (setupEvt),
    .outRcvEvt (outRcvEvt),
    .prepDone  (prepDone),
    .busy      (busy),
    .strb      (strb)
  );

  ep0_guard_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .startPrep (startPrep),
    .dropCount (dropCount)
  );

endmodule

// File: rtl/ep0_rearm_guard_chk.sv
module ep0_rearm_guard_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             nakEvt,
  input logic             setupEvt,
  input logic             outRcvEvt,
  input logic             prepDone,
  input logic             startPrep,
  input logic             busy,
  input logic [CNT_W-1:0] dropCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    startPrep |-> busy);  // R1

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    startPrep |=> !startPrep);  // R1

  AST_NESTED_NAK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (nakEvt && busy && !setupEvt && !outRcvEvt) |=> (!startPrep && busy));  // R2

  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    setupEvt |=> !busy);  // R3

  AST_OUTRCV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    outRcvEvt |=> !busy);  // R4

  AST_DONE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && prepDone && !setupEvt && !outRcvEvt) |=> busy);  // R5

  AST_CLEAR_BEATS_NAK: assert property (@(posedge clk) disable iff (rst)
    ((setupEvt || outRcvEvt) && nakEvt) |=> !startPrep);  // R6

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (dropCount == CNT_MAX) |=> (dropCount == CNT_MAX));  // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (dropCount != CNT_MAX) |=> (dropCount == $past(dropCount) ||
                                dropCount == $past(dropCount) + 1'b1));  // R7

  always @(posedge clk) begin
    if ($past(rst)) begin
      AST_RESET_CLEAR: assert (!busy && !startPrep && dropCount == '0);  // R9
    end
  end

endmodule

bind ep0_rearm_guard ep0_rearm_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nakEvt    (nakEvt),
  .setupEvt  (setupEvt),
  .outRcvEvt (outRcvEvt),
  .prepDone  (prepDone),
  .startPrep (startPrep),
  .busy      (busy),
  .dropCount (dropCount)
);

// File: tb/ep0_rearm_guard_test.sv
`timescale 1ns/1ps
module ep0_rearm_guard_test;

  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nakEvt = 1'b0, setupEvt = 1'b0, outRcvEvt = 1'b0, prepDone = 1'b0;
  logic startPrep, busy;
  logic [CNT_W-1:0] dropCount;

  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ep0_rearm_guard #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .nakEvt(nakEvt), .setupEvt(setupEvt),
    .outRcvEvt(outRcvEvt), .prepDone(prepDone),
    .startPrep(startPrep), .busy(busy), .dropCount(dropCount)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one cycle of events; returns at the next falling edge
  task automatic pulse(bit n, bit s, bit o, bit d);
    nakEvt = n; setupEvt = s; outRcvEvt = o; prepDone = d;
    @(negedge clk);
    nakEvt = 0; setupEvt = 0; outRcvEvt = 0; prepDone = 0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9", "busy", busy, 0);
    check("R9", "startPrep", startPrep, 0);
    check("R9", "dropCount", dropCount, 0);
  endtask

  task automatic t_first_nak();
    pulse(1, 0, 0, 0);
    check("R1", "startPrep", startPrep, 1);
    check("R1", "busy", busy, 1);
    idle_cycle();
    check("R1", "startPrep after", startPrep, 0);
  endtask

  task automatic t_nested_nak();
    for (int i = 0; i < 2; i++) begin
      pulse(1, 0, 0, 0);
      expCnt++;
      check("R2", "startPrep", startPrep, 0);
      check("R2", "busy", busy, 1);
      check("R7", "dropCount", dropCount, expCnt);
    end
  endtask

  task automatic t_prep_done();
    pulse(0, 0, 0, 1);
    check("R5", "busy", busy, 1);
    check("R5", "startPrep", startPrep, 0);
    check("R5", "dropCount", dropCount, expCnt);
    pulse(1, 0, 0, 0);
    expCnt++;
    check("R2", "startPrep queued", startPrep, 0);
    check("R7", "dropCount queued", dropCount, expCnt);
  endtask

  task automatic t_setup_clear();
    pulse(0, 1, 0, 0);
    check("R3", "busy", busy, 0);
    check("R3", "startPrep", startPrep, 0);
    pulse(1, 0, 0, 0);
    check("R1", "restart startPrep", startPrep, 1);
  endtask

  task automatic t_outrcv_clear();
    idle_cycle();
    pulse(0, 0, 1, 0);
    check("R4", "busy", busy, 0);
    check("R4", "startPrep", startPrep, 0);
  endtask

  task automatic t_coincide(bit s, bit o);
    pulse(1, 0, 0, 0);
    idle_cycle();
    check("R6", "busy before", busy, 1);
    pulse(1, s, o, 0);
    check("R6", "busy after clear", busy, 0);
    check("R6", "no early start", startPrep, 0);
    idle_cycle();
    check("R6", "deferred start", startPrep, 1);
    check("R6", "busy deferred", busy, 1);
    check("R6", "dropCount", dropCount, expCnt);
    idle_cycle();
    check("R6", "start single", startPrep, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) begin
      pulse(1, 0, 0, 0);
      if (expCnt < CNT_MAX) expCnt++;
    end
    check("R8", "saturated", dropCount, CNT_MAX);
    check("R7", "tracked", dropCount, expCnt);
    pulse(1, 0, 0, 0);
    check("R8", "held", dropCount, CNT_MAX);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_nak();
    t_nested_nak();
    t_prep_done();
    t_setup_clear();
    t_outrcv_clear();
    t_coincide(1, 0);
    pulse(0, 0, 1, 0);
    t_coincide(0, 1);
    t_saturate();
    rst = 1'b1;
    idle_cycle();
    rst = 1'b0;
    t_reset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule